// File: doc/BRIEF.md
# Dual latched countdown timer unit

This peripheral holds two 16-bit down-counters behind an 8-bit register bus with a 4-bit address. The first counter runs without stopping. It counts from a 16-bit reload value down through zero, stays one tick on 0xFFFF, and then starts again from the reload value. The second counter is loaded once and then keeps counting down, wrapping from zero to 0xFFFF and never reloading. Both counters advance only in cycles where the shared count-enable input is high. Each time either counter lands on zero it raises its own flag.

Software reaches the counters one byte at a time. Some accesses have side effects: writing the high byte of the first counter reloads it, certain writes and reads clear a flag, and writing the high byte of the second counter starts it. A flag register and an enable register combine the two events onto one interrupt line.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset, both counters hold 0xFFFF, the timer-1 reload value is 0xFFFF, the stored timer-2 low byte is 0x00, the flag and enable registers are 0, and irq is low.
- R2: A counter changes only in a cycle where cnt_en is high or where that counter is loaded by a bus write. With cnt_en low, the counts stay constant.
- R3: Each enabled tick moves timer 1 one step along the loop L, L-1, ..., 0, 0xFFFF, L, where L is its reload value. One full loop therefore takes L+2 ticks.
- R4: A write to address 5 sets the high byte of the reload value and loads the counter with the whole new reload value. It also clears flag bit 6. When a decrement falls in the same cycle, the load wins.
- R5: Writes to address 4 or 6 set the low byte of the reload value, and a write to address 7 sets its high byte. None of these three writes touches the counter. A write to address 7 also clears flag bit 6.
- R6: Reads of addresses 4 and 5 return the low and high bytes of the live timer-1 count. Reads of addresses 6 and 7 return the low and high bytes of the reload value. Read data appears on bus_rdata in the cycle after the read strobe and reflects the state in the strobe cycle.
- R7: A write to address 8 stores a low byte. A write to address 9 loads timer 2 with that stored byte as its low half and the written byte as its high half. Timer 2 decrements modulo 2^16 with no reload.
- R8: A read of address 8 returns the low byte of the timer-2 count and clears flag bit 5. A read of address 9 returns the high byte.
- R9: When a tick brings timer 1 to zero, flag bit 6 is set on the following cycle. When a tick brings timer 2 to zero, flag bit 5 is set on the following cycle. A flag stays set until something clears it.
- R10: A flag set event beats any clear of the same bit in the same cycle.
- R11: Address 14 is the enable register. A write with bit 7 set turns on the written ones in bits 6..0. A write with bit 7 clear turns those bits off. A read returns the enable bits with bit 7 as 0.
- R12: Address 13 is the flag register. A write clears each flag whose bit is written as 1. A read returns the flags with bit 7 equal to irq. irq is high exactly when some flag bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count tick for both timers |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can fall in the same cycle: a counter reaching zero and a bus access that clears that counter's flag. The bench provokes this on purpose. It raises cnt_en in the very cycle that carries the timer-2 low-byte read, and again in the cycle that carries the timer-1 reload-high write, with each counter at 1. It then reads the flag register and expects both flags to remain set. A third collision pairs a tick with the address-5 load. After it, the count must equal the reload value exactly, with no decrement applied.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  // Register offsets (4-bit address space)
  localparam logic [3:0] ADR_T1_CNT_LO = 4'd4;
  localparam logic [3:0] ADR_T1_CNT_HI = 4'd5;
  localparam logic [3:0] ADR_T1_LAT_LO = 4'd6;
  localparam logic [3:0] ADR_T1_LAT_HI = 4'd7;
  localparam logic [3:0] ADR_T2_LO     = 4'd8;
  localparam logic [3:0] ADR_T2_HI     = 4'd9;
  localparam logic [3:0] ADR_FLAGS     = 4'd13;
  localparam logic [3:0] ADR_ENABLE    = 4'd14;

  // Flag bit positions
  localparam int FLG_T1 = 6;
  localparam int FLG_T2 = 5;
endpackage

// File: rtl/tmr_reload_counter.sv
`timescale 1ns/1ps
module tmr_reload_counter #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            lat_lo_we,
  input  logic            lat_hi_we,
  input  logic            start,
  input  logic [BW-1:0]   wbyte,
  output logic [2*BW-1:0] count,
  output logic [2*BW-1:0] latch,
  output logic            expire
);
  localparam int CW = 2*BW;

  logic [CW-1:0] cnt_q, cnt_d, lat_q, lat_d;
  logic          under_q, under_d;

  always_comb begin
    lat_d = lat_q;
    if (lat_lo_we) lat_d[BW-1:0]  = wbyte;
    if (lat_hi_we) lat_d[CW-1:BW] = wbyte;
  end

  always_comb begin
    cnt_d   = cnt_q;
    under_d = under_q;
    if (start) begin
      cnt_d   = {wbyte, lat_q[BW-1:0]};
      under_d = 1'b0;
    end else if (tick) begin
      if (under_q) begin
        cnt_d   = lat_q;
        under_d = 1'b0;
      end else begin
        cnt_d   = cnt_q - 1'b1;
        under_d = (cnt_q == '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '1;
      lat_q   <= '1;
      under_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      lat_q   <= lat_d;
      under_q <= under_d;
    end
  end

  assign count  = cnt_q;
  assign latch  = lat_q;
  assign expire = tick && !start && (cnt_d == '0);

  a_r1_t1_reset: assert property (@(posedge clk)
    rst |=> (cnt_q == '1 && lat_q == '1));
  a_r2_t1_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start) |=> $stable(cnt_q));
  a_r3_pass_ffff: assert property (@(posedge clk) disable iff (rst)
    (tick && !start && !under_q && cnt_q == '0) |=> (cnt_q == '1));
  a_r3_reload: assert property (@(posedge clk) disable iff (rst)
    (tick && !start && under_q) |=> (cnt_q == $past(lat_q)));
  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt_q == {$past(wbyte), $past(lat_q[BW-1:0])}));
endmodule

// File: rtl/tmr_wrap_counter.sv
`timescale 1ns/1ps
module tmr_wrap_counter #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            lo_we,
  input  logic            hi_we,
  input  logic [BW-1:0]   wbyte,
  output logic [2*BW-1:0] count,
  output logic            expire
);
  localparam int CW = 2*BW;

  logic [BW-1:0] lo_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (hi_we)     cnt_d = {wbyte, lo_q};
    else if (tick) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      cnt_q <= '1;
    end else begin
      if (lo_we) lo_q <= wbyte;
      cnt_q <= cnt_d;
    end
  end

  assign count  = cnt_q;
  assign expire = tick && !hi_we && (cnt_d == '0);

  a_r1_t2_reset: assert property (@(posedge clk)
    rst |=> (cnt_q == '1 && lo_q == '0));
  a_r2_t2_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !hi_we) |=> $stable(cnt_q));
  a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !hi_we && cnt_q == '0) |=> (cnt_q == '1));
  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    (hi_we && !lo_we) |=> (cnt_q == {$past(wbyte), lo_q}));
endmodule

// File: rtl/tmr_irq_ctrl.sv
`timescale 1ns/1ps
module tmr_irq_ctrl #(
  parameter int FN = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FN-1:0] set_evt,
  input  logic [FN-1:0] clr_evt,
  input  logic          en_wr,
  input  logic          en_on,
  input  logic [FN-1:0] en_bits,
  output logic [FN-1:0] flags,
  output logic [FN-1:0] enables,
  output logic          irq
);
  for (genvar i = 0; i < FN; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i]   <= 1'b0;
        enables[i] <= 1'b0;
      end else begin
        if (set_evt[i])      flags[i] <= 1'b1;
        else if (clr_evt[i]) flags[i] <= 1'b0;
        if (en_wr && en_bits[i]) enables[i] <= en_on;
      end
    end
  end

  assign irq = |(flags & enables);

  a_r1_irq_reset: assert property (@(posedge clk)
    rst |=> (flags == '0 && enables == '0));
  a_r9_set: assert property (@(posedge clk) disable iff (rst)
    (|set_evt) |=> ((flags & $past(set_evt)) == $past(set_evt)));
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (|(clr_evt & ~set_evt)) |=> ((flags & $past(clr_evt & ~set_evt)) == '0));
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|(clr_evt & set_evt)) |=> ((flags & $past(clr_evt & set_evt)) == $past(clr_evt & set_evt)));
  a_r12_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((|set_evt) || en_wr));
endmodule

// File: rtl/dual_timer_unit.sv
`timescale 1ns/1ps
module dual_timer_unit #(
  parameter int BW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_en,
  input  logic [AW-1:0] bus_addr,
  input  logic [BW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [BW-1:0] bus_rdata,
  output logic          irq
);
  import tmr_pkg::*;

  localparam int CW = 2*BW;
  localparam int FN = BW-1;

  logic w_t1lo, w_t1hi, w_l1lo, w_l1hi, w_t2lo, w_t2hi, w_flg, w_ena;
  logic r_t2lo;

  assign w_t1lo = bus_wr && (bus_addr == AW'(ADR_T1_CNT_LO));
  assign w_t1hi = bus_wr && (bus_addr == AW'(ADR_T1_CNT_HI));
  assign w_l1lo = bus_wr && (bus_addr == AW'(ADR_T1_LAT_LO));
  assign w_l1hi = bus_wr && (bus_addr == AW'(ADR_T1_LAT_HI));
  assign w_t2lo = bus_wr && (bus_addr == AW'(ADR_T2_LO));
  assign w_t2hi = bus_wr && (bus_addr == AW'(ADR_T2_HI));
  assign w_flg  = bus_wr && (bus_addr == AW'(ADR_FLAGS));
  assign w_ena  = bus_wr && (bus_addr == AW'(ADR_ENABLE));
  assign r_t2lo = bus_rd && (bus_addr == AW'(ADR_T2_LO));

  logic [CW-1:0] t1_cnt, t1_lat, t2_cnt;
  logic          t1_exp, t2_exp;

  tmr_reload_counter #(.BW(BW)) u_t1 (
    .clk(clk), .rst(rst), .tick(cnt_en),
    .lat_lo_we(w_t1lo || w_l1lo), .lat_hi_we(w_t1hi || w_l1hi),
    .start(w_t1hi), .wbyte(bus_wdata),
    .count(t1_cnt), .latch(t1_lat), .expire(t1_exp)
  );

  tmr_wrap_counter #(.BW(BW)) u_t2 (
    .clk(clk), .rst(rst), .tick(cnt_en),
    .lo_we(w_t2lo), .hi_we(w_t2hi), .wbyte(bus_wdata),
    .count(t2_cnt), .expire(t2_exp)
  );

  logic [FN-1:0] set_v, clr_v, flags, enables;

  always_comb begin
    set_v = '0;
    set_v[FLG_T1] = t1_exp;
    set_v[FLG_T2] = t2_exp;
    clr_v = w_flg ? bus_wdata[FN-1:0] : '0;
    if (w_t1hi || w_l1hi) clr_v[FLG_T1] = 1'b1;
    if (r_t2lo)           clr_v[FLG_T2] = 1'b1;
  end

  tmr_irq_ctrl #(.FN(FN)) u_irq (
    .clk(clk), .rst(rst), .set_evt(set_v), .clr_evt(clr_v),
    .en_wr(w_ena), .en_on(bus_wdata[BW-1]), .en_bits(bus_wdata[FN-1:0]),
    .flags(flags), .enables(enables), .irq(irq)
  );

  logic [BW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if      (bus_addr == AW'(ADR_T1_CNT_LO)) rd_mux = t1_cnt[BW-1:0];
    else if (bus_addr == AW'(ADR_T1_CNT_HI)) rd_mux = t1_cnt[CW-1:BW];
    else if (bus_addr == AW'(ADR_T1_LAT_LO)) rd_mux = t1_lat[BW-1:0];
    else if (bus_addr == AW'(ADR_T1_LAT_HI)) rd_mux = t1_lat[CW-1:BW];
    else if (bus_addr == AW'(ADR_T2_LO))     rd_mux = t2_cnt[BW-1:0];
    else if (bus_addr == AW'(ADR_T2_HI))     rd_mux = t2_cnt[CW-1:BW];
    else if (bus_addr == AW'(ADR_FLAGS))     rd_mux = {irq, flags};
    else if (bus_addr == AW'(ADR_ENABLE))    rd_mux = {1'b0, enables};
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  a_r6_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  a_r12_status_bit: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AW'(ADR_FLAGS)) |=> (bus_rdata[BW-1] == $past(irq)));
endmodule

// File: tb/sim_dual_timer_unit.sv
`timescale 1ns/1ps
module sim_dual_timer_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dual_timer_unit u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input int exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, $sformatf("read addr %0d", a), d, exp);
  endtask

  task automatic ticks(input int n);
    cnt_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "irq", irq, 0);
    rd_chk("R1", 4, 8'hFF); rd_chk("R1", 5, 8'hFF);
    rd_chk("R1", 6, 8'hFF); rd_chk("R1", 7, 8'hFF);
    rd_chk("R1", 8, 8'hFF); rd_chk("R1", 9, 8'hFF);
    rd_chk("R1", 13, 8'h00); rd_chk("R1", 14, 8'h00);
    wr(9, 8'hFF); // R1: stored low byte is 0
    rd_chk("R1", 8, 8'h00);
  endtask

  task automatic t_hold;
    repeat (10) @(negedge clk);
    rd_chk("R2", 4, 8'hFF); rd_chk("R2", 5, 8'hFF);
  endtask

  task automatic t_t1_load;
    wr(4, 8'h03);
    rd_chk("R5", 4, 8'hFF);          // counter untouched
    rd_chk("R5", 6, 8'h03);
    wr(5, 8'h00);
    rd_chk("R4", 4, 8'h03); rd_chk("R4", 5, 8'h00);
    rd_chk("R6", 6, 8'h03); rd_chk("R6", 7, 8'h00);
  endtask

  task automatic t_t1_period;
    ticks(3);
    rd_chk("R3", 4, 8'h00); rd_chk("R3", 5, 8'h00);
    rd_chk("R9", 13, 8'h40);
    ticks(1);
    rd_chk("R3", 4, 8'hFF); rd_chk("R3", 5, 8'hFF);
    ticks(1);
    rd_chk("R3", 4, 8'h03); rd_chk("R3", 5, 8'h00);
    rd_chk("R9", 13, 8'h40);         // flag persists
  endtask

  task automatic t_irq;
    wr(14, 8'hC0);
    chk("R12", "irq after enable", irq, 1);
    rd_chk("R12", 13, 8'hC0);
    rd_chk("R11", 14, 8'h40);
    wr(13, 8'h40);
    chk("R12", "irq after flag clear", irq, 0);
    rd_chk("R12", 13, 8'h00);
  endtask

  task automatic t_t1_hi_latch;
    ticks(3);                        // 3 -> 0
    chk("R9", "irq on t1 zero", irq, 1);
    wr(7, 8'h12);
    chk("R5", "irq after addr7 write", irq, 0);
    rd_chk("R5", 4, 8'h00); rd_chk("R5", 5, 8'h00);
    rd_chk("R6", 7, 8'h12);
    ticks(2);                        // 0 -> FFFF -> 1203
    rd_chk("R3", 4, 8'h03); rd_chk("R3", 5, 8'h12);
  endtask

  task automatic t_load_priority;
    wr(5, 8'h00);                    // latch 0x0003, count 3
    ticks(3);
    rd_chk("R9", 13, 8'hC0);
    cnt_en = 1'b1;                   // tick and load in the same cycle
    wr(5, 8'h00);
    cnt_en = 1'b0;
    rd_chk("R4", 4, 8'h03); rd_chk("R4", 5, 8'h00);
    rd_chk("R4", 13, 8'h00);
  endtask

  task automatic t_t2;
    wr(4, 8'h00); wr(5, 8'h10);      // park timer 1 far from zero
    wr(13, 8'h7F);
    wr(8, 8'h02); wr(9, 8'h00);
    rd_chk("R7", 8, 8'h02); rd_chk("R8", 9, 8'h00);
    ticks(2);
    rd_chk("R9", 13, 8'h20);
    ticks(1);
    rd_chk("R7", 9, 8'hFF);
    rd_chk("R8", 8, 8'hFF);
    rd_chk("R8", 13, 8'h00);         // low-byte read cleared it
    wr(9, 8'h01);
    rd_chk("R7", 8, 8'h02); rd_chk("R7", 9, 8'h01);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    wr(14, 8'hA0);                   // enables 0x60
    rd_chk("R11", 14, 8'h60);
    wr(8, 8'h01); wr(9, 8'h00);
    cnt_en = 1'b1;                   // t2 reaches 0 while addr 8 is read
    rd(8, d);
    cnt_en = 1'b0;
    chk("R8", "collision read data", d, 8'h01);
    rd_chk("R10", 13, 8'hA0);
    chk("R10", "irq kept", irq, 1);
    wr(4, 8'h01); wr(5, 8'h00);
    cnt_en = 1'b1;                   // t1 reaches 0 while addr 7 is written
    wr(7, 8'h00);
    cnt_en = 1'b0;
    rd_chk("R10", 13, 8'hE0);
    rd_chk("R3", 4, 8'h00);
    wr(13, 8'h60);
    chk("R12", "irq cleared", irq, 0);
    rd_chk("R12", 13, 8'h00);
    wr(14, 8'h20);
    rd_chk("R11", 14, 8'h40);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_hold();
    t_t1_load();
    t_t1_period();
    t_irq();
    t_t1_hi_latch();
    t_load_priority();
    t_t2();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule